// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator with Independent Receive Phase

This block produces the two bit-rate strobes for a UART, one for the transmitter and one for the receiver. Both come from a single programmable 8-bit reload byte. A shared prescaler selects one of five timer clock sources. Each timer clock step advances two 8-bit up-counters. When a counter passes 0xFF, it reloads from the reload byte and toggles its own halving flip-flop. Every second wrap produces a one-cycle tick. The resulting rate is the timer clock frequency divided by (256 − reload), then divided by 2.

The transmit counter runs freely. The receive counter is a private copy that uses the same reload byte. When the start-bit detector reports a start edge, the receive counter alone is forced back to the reload byte and its halving flip-flop is cleared. This lets a reception align to the incoming frame at any moment, whatever phase the transmit counter has. All prescaled sources are clock enables in the system clock domain. The external oscillator is synchronized and edge-detected before its divide-by-8 stage.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst` is high, `tx_tick` and `rx_tick` stay low. Reset sets both counters to 0 and clears both halving flip-flops.
- R2: With `src_sel` code 0 (system clock), 1 (÷4), 2 (÷12) or 3 (÷48), consecutive `tx_tick` pulses are 2·(256 − `reload`)·P system cycles apart, where P is 1, 4, 12 or 48.
- R3: With `src_sel` code 4, the timer advances once per 8 rising edges of `ext_clk`. When `ext_clk` has a 6-cycle period, ticks are 2·(256 − `reload`)·48 system cycles apart.
- R4: While `timer_en` is low, neither tick is produced and both counters hold. Holding `timer_en` low for d cycles lengthens the current tick interval by exactly d cycles.
- R5: Each tick is high for a single cycle and is never high in two consecutive cycles.
- R6: When `rx_start` is captured while `timer_en` is high, the receive counter is loaded with `reload` and its halving flip-flop is cleared. With source code 0, the next `rx_tick` appears 2·(256 − `reload`) cycles after the capturing edge, and the following ticks keep the normal period.
- R7: `rx_start` has no effect on `tx_tick`, which keeps its period and phase.
- R8: A new `reload` value applies only from the next wrap. The interval that contains the change is (256 − old) + (256 − new) timer steps long.
- R9: If no start is seen after reset, `rx_tick` and `tx_tick` coincide.
- R10: `src_sel` codes 5 to 7 produce no timer steps and no ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External oscillator, asynchronous to `clk` |
| src_sel | input | 3 | Timer clock source code (0..4 valid) |
| reload | input | 8 | Shared reload byte |
| timer_en | input | 1 | Timer run enable |
| rx_start | input | 1 | One-cycle start-edge pulse from the receive detector |
| tx_tick | output | 1 | One-cycle transmit bit-rate tick |
| rx_tick | output | 1 | One-cycle receive bit-rate tick |

## Verification
The tick period is measured for several reload bytes with the system clock: 255 for the shortest interval, 200 for a middle value, and 0 for the full 256-step range. This separates an off-by-one in the wrap count from a missing halving stage. Each prescaled source and the external path are then run at one reload value, so that a wrong divisor shows up as a period error of a known multiple. A start pulse placed in mid-interval shows whether the receive counter alone realigns. A reload change made right after a tick and an enable gap of known length show whether the reload and hold timing is right.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [2:0] {
        SRC_SYS   = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV12 = 3'd2,
        SRC_DIV48 = 3'd3,
        SRC_EXT8  = 3'd4
    } src_sel_e;

    localparam int NUM_DIV = 3;

    // divisor applied by prescaler stage i (source codes 1..3)
    function automatic int div_of(input int i);
        case (i)
            0:       return 4;
            1:       return 12;
            default: return 48;
        endcase
    endfunction

    typedef struct packed {
        logic step;   // advance counter this cycle
        logic load;   // force reload, clear halving flop
    } tmr_ctl_t;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int EXT_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_clk,
    input  logic [2:0] src_sel,
    output logic       step_en
);
    localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

    logic [NUM_DIV-1:0] div_tick;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        localparam int D  = div_of(g);
        localparam int CW = $clog2(D);
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)                      cnt <= '0;
            else if (cnt == CW'(D - 1))   cnt <= '0;
            else                          cnt <= cnt + 1'b1;
        end
        assign div_tick[g] = (cnt == CW'(D - 1));
    end

    // external oscillator: two-flop synchronizer plus edge history flop
    logic [2:0]    sync_q;
    logic          ext_rise;
    logic [EW-1:0] ext_cnt;
    logic          ext_tick;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ext_clk};
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst)                                   ext_cnt <= '0;
        else if (ext_rise && ext_cnt == EW'(EXT_DIV - 1)) ext_cnt <= '0;
        else if (ext_rise)                         ext_cnt <= ext_cnt + 1'b1;
    end

    assign ext_tick = ext_rise && (ext_cnt == EW'(EXT_DIV - 1));

    always_comb begin
        case (src_sel_e'(src_sel))
            SRC_SYS:   step_en = 1'b1;
            SRC_DIV4:  step_en = div_tick[0];
            SRC_DIV12: step_en = div_tick[1];
            SRC_DIV48: step_en = div_tick[2];
            SRC_EXT8:  step_en = ext_tick;
            default:   step_en = 1'b0;
        endcase
    end

    // R2: the divider chains run in lockstep, so the slowest stage's strobe lands on the faster ones
    assert_nested_divs_R2: assert property (@(posedge clk) disable iff (rst)
        div_tick[2] |-> (div_tick[1] && div_tick[0]));

    // R10: reserved source codes never step the timer
    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (src_sel > 3'd4) |-> !step_en);

endmodule

// File: rtl/baud_timer.sv
module baud_timer
    import baud_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_ctl_t     ctl,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         half;
    logic         wrap;

    assign wrap = ctl.step && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            half <= 1'b0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (ctl.load) begin
                cnt  <= reload;
                half <= 1'b0;
            end else if (wrap) begin
                cnt  <= reload;
                half <= ~half;
                tick <= half;
            end else if (ctl.step) begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

    // R2: counting step advances by one below the top value
    assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.load && cnt != '1) |=> (cnt == $past(cnt) + W'(1)));

    // R4: no step and no load keeps the counter frozen
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.step && !ctl.load) |=> $stable(cnt));

    // R5: a tick is never followed by another tick
    assert_single_tick_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R6: forced load takes the reload byte and resets the halving flop
    assert_force_load_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (cnt == $past(reload) && !half && !tick));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import baud_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int EXT_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk,
    input  logic [2:0]       src_sel,
    input  logic [CNT_W-1:0] reload,
    input  logic             timer_en,
    input  logic             rx_start,
    output logic             tx_tick,
    output logic             rx_tick
);
    logic     step_en;
    tmr_ctl_t tx_ctl;
    tmr_ctl_t rx_ctl;

    baud_prescaler #(.EXT_DIV(EXT_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .src_sel (src_sel),
        .step_en (step_en)
    );

    always_comb begin
        tx_ctl.step = timer_en & step_en;
        tx_ctl.load = 1'b0;
        rx_ctl.step = timer_en & step_en;
        rx_ctl.load = timer_en & rx_start;
    end

    baud_timer #(.W(CNT_W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .ctl    (tx_ctl),
        .reload (reload),
        .tick   (tx_tick)
    );

    baud_timer #(.W(CNT_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .ctl    (rx_ctl),
        .reload (reload),
        .tick   (rx_tick)
    );

    // R4: a disabled timer emits nothing on either path
    assert_quiet_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        !timer_en |=> (!tx_tick && !rx_tick));

    // R1: ticks stay low through reset
    always_ff @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (!tx_tick || !$past(rst));
        end
    end

endmodule

// File: tb/uart_baud_gen_bench.sv
`timescale 1ns/1ps
module uart_baud_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic [2:0] src_sel = 3'd0;
    logic [7:0] reload = 8'd0;
    logic       timer_en = 1'b0;
    logic       rx_start = 1'b0;
    logic       tx_tick;
    logic       rx_tick;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    longint cyc = 0;
    longint tx_q[$];
    longint rx_q[$];
    logic  prev_tx = 1'b0;
    logic  prev_rx = 1'b0;

    always #2 clk = ~clk;

    initial begin
        #0.5;
        forever #12 ext_clk = ~ext_clk;
    end

    uart_baud_gen u_uart_baud_gen (
        .clk      (clk),
        .rst      (rst),
        .ext_clk  (ext_clk),
        .src_sel  (src_sel),
        .reload   (reload),
        .timer_en (timer_en),
        .rx_start (rx_start),
        .tx_tick  (tx_tick),
        .rx_tick  (rx_tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: record tick times and check pulse width (R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_tick) begin
                tx_q.push_back(cyc);
                check(!prev_tx, "R5 tx adjacent", 1, 0);
            end
            if (rx_tick) begin
                rx_q.push_back(cyc);
                check(!prev_rx, "R5 rx adjacent", 1, 0);
            end
        end
        prev_tx = tx_tick;
        prev_rx = rx_tick;
    end

    task automatic step_cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [2:0] s, input logic [7:0] r, input logic en);
        rst = 1'b1;
        timer_en = 1'b0;
        rx_start = 1'b0;
        repeat (3) step_cyc();
        tx_q.delete();
        rx_q.delete();
        src_sel = s;
        reload = r;
        timer_en = en;
        rst = 1'b0;
    endtask

    task automatic wait_tx(input int n);
        while (tx_q.size() < n) step_cyc();
    endtask

    task automatic run_period(input logic [2:0] s, input logic [7:0] r, input int p, input string req);
        longint exp;
        do_reset(s, r, 1'b1);
        wait_tx(4);
        exp = 2 * (256 - r) * p;
        check(tx_q[2] - tx_q[1] == exp, req, tx_q[2] - tx_q[1], exp);
        check(tx_q[3] - tx_q[2] == exp, req, tx_q[3] - tx_q[2], exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        longint t;
        longint c;
        longint rx_first;
        longint rx_second;
        longint tx_first;
        longint tx_second;

        // R1: outputs low during reset
        step_cyc();
        check(!tx_tick && !rx_tick, "R1 reset outputs", {tx_tick, rx_tick}, 0);

        // R4: disabled timer is silent
        do_reset(3'd0, 8'd250, 1'b0);
        repeat (600) step_cyc();
        check(tx_q.size() == 0 && rx_q.size() == 0, "R4 disabled quiet", tx_q.size() + rx_q.size(), 0);

        // R10: reserved source codes
        for (int code = 5; code < 8; code++) begin
            do_reset(3'(code), 8'd255, 1'b1);
            repeat (400) step_cyc();
            check(tx_q.size() == 0 && rx_q.size() == 0, "R10 reserved source", tx_q.size() + rx_q.size(), 0);
        end

        // R2: system clock, several reload bytes
        run_period(3'd0, 8'd255, 1, "R2 sysclk reload 255");
        run_period(3'd0, 8'd200, 1, "R2 sysclk reload 200");
        run_period(3'd0, 8'd0, 1, "R2 sysclk reload 0");
        // R9: receive ticks coincide with transmit ticks without a start
        check(rx_q.size() >= 4 && rx_q[0] == tx_q[0] && rx_q[3] == tx_q[3], "R9 rx equals tx",
              rx_q.size() >= 4 ? rx_q[3] : -1, tx_q[3]);

        // R2: prescaled sources
        run_period(3'd1, 8'd250, 4, "R2 div4");
        run_period(3'd2, 8'd250, 12, "R2 div12");
        run_period(3'd3, 8'd250, 48, "R2 div48");

        // R3: external oscillator, 6-cycle period, /8 per step
        run_period(3'd4, 8'd252, 48, "R3 ext div8");

        // R4: enable gap lengthens interval by its duration
        do_reset(3'd0, 8'd250, 1'b1);
        wait_tx(2);
        t = tx_q[1];
        timer_en = 1'b0;
        repeat (5) step_cyc();
        timer_en = 1'b1;
        wait_tx(3);
        check(tx_q[2] - t == 12 + 5, "R4 hold extends interval", tx_q[2] - t, 17);

        // R8: reload change applies from next wrap
        do_reset(3'd0, 8'd250, 1'b1);
        wait_tx(2);
        t = tx_q[1];
        reload = 8'd240;
        wait_tx(4);
        check(tx_q[2] - t == 6 + 16, "R8 mixed interval", tx_q[2] - t, 22);
        check(tx_q[3] - tx_q[2] == 32, "R8 new period", tx_q[3] - tx_q[2], 32);

        // R6 / R7: start pulse realigns receive only
        do_reset(3'd0, 8'd250, 1'b1);
        wait_tx(2);
        t = tx_q[1];
        repeat (3) step_cyc();
        c = cyc;
        rx_start = 1'b1;
        step_cyc();
        rx_start = 1'b0;
        repeat (40) step_cyc();
        rx_first = -1; rx_second = -1;
        foreach (rx_q[k]) begin
            if (rx_q[k] > c && rx_first < 0) rx_first = rx_q[k];
            else if (rx_q[k] > c && rx_second < 0) rx_second = rx_q[k];
        end
        tx_first = -1; tx_second = -1;
        foreach (tx_q[k]) begin
            if (tx_q[k] > c && tx_first < 0) tx_first = tx_q[k];
            else if (tx_q[k] > c && tx_second < 0) tx_second = tx_q[k];
        end
        check(rx_first == c + 1 + 12, "R6 first rx after start", rx_first, c + 13);
        check(rx_second == c + 1 + 24, "R6 rx period after start", rx_second, c + 25);
        check(tx_first == t + 12, "R7 tx phase kept", tx_first, t + 12);
        check(tx_second == t + 24, "R7 tx period kept", tx_second, t + 24);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule